// File: doc/BRIEF.md
# Split-Word Host-to-Processor Mailbox

This block passes 32-bit words in both directions between a 16-bit external host bus and a 32-bit internal processor bus. Both buses share one clock. The host sends a word inbound in two 16-bit writes, low half first. Writing the upper half marks the inbound word as ready for the processor. When the processor reads the whole word, the ready mark drops.

In the other direction, the processor writes a full 32-bit outbound word and an outbound-ready flag is raised. The host fetches that word in two 16-bit reads. Reading the upper half drops the flag. The host reaches the mailbox through a 4-bit bank select and a 2-bit local address, and a status location lets the host poll the outbound flag.

Both buses use single-cycle strobes. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read strobe on the same bus.

Top module: `hcpu_mailbox`

## Requirements
- R1: After reset, all four 16-bit mailbox halves are 0x0000. Both ready flags and both read-data outputs are 0.
- R2: The host can write and read back the inbound halves at bank 4'b0010: the low half at local address 2'b00 and the high half at 2'b01. A processor read returns {high, low} as a 32-bit word.
- R3: A host write to the inbound high half sets `in_ready`. A host write to the inbound low half leaves `in_ready` unchanged.
- R4: A processor read (`p_rd`) clears `in_ready`. If a host write to the inbound high half happens in the same cycle, `in_ready` stays set.
- R5: A processor write (`p_wr`) loads the 32-bit outbound word and sets `out_ready`. The host reads the outbound low half at bank 4'b0011, local address 2'b00, and the high half at 2'b01.
- R6: A host read of the outbound high half clears `out_ready`, and a host read of the outbound low half leaves it unchanged. If a processor write happens in the same cycle as a clearing read, `out_ready` stays set.
- R7: A host read at bank 4'b0011, local address 2'b10, returns a status word. Bit 0 of that word is `out_ready` and all other bits are 0. Reading the status word changes no flag.
- R8: Host writes to bank 4'b0011 are ignored, and the outbound word is unchanged.
- R9: Host reads of unmapped locations return 0x0000. The unmapped locations are local address 2'b10 or 2'b11 in bank 4'b0010, local address 2'b11 in bank 4'b0011, and any address in any other bank. Host writes to unmapped locations change nothing.
- R10: Read data appears one cycle after the read strobe and holds its value until the next read strobe on the same bus.
- R11: When a read and a write of the same location fall in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| h_bank | input | 4 | Host bank select |
| h_addr | input | 2 | Host local address |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, registered |
| p_wr | input | 1 | Processor write strobe for the outbound word |
| p_wdata | input | 32 | Processor outbound write data |
| p_rd | input | 1 | Processor read strobe for the inbound word |
| p_rdata | output | 32 | Processor read data, registered |
| in_ready | output | 1 | Inbound word holds new data |
| out_ready | output | 1 | Outbound word is waiting for the host |

## Verification
Each half is written with a distinct value. A swapped half or a wrong address decode therefore shows up as a wrong readback. Low-half and high-half accesses are tried one at a time, so that a flag tied to the wrong half is exposed.

Colliding cycles are also tried:
- a processor read together with an inbound high-half write;
- a host high-half read together with a processor write.

These cycles separate a set-wins flag from a clear-wins flag, and read-old-data from read-new-data. Writes to the outbound bank and accesses to unmapped locations are followed by readbacks, which show that nothing was disturbed. Idle cycles after a read show whether the read data holds.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Which host location a bank/address pair selects
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN_LO,
    SEL_IN_HI,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_STATUS
  } host_sel_e;

endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mbox_host_decode.sv
module mbox_host_decode
  import mbox_pkg::*;
#(
  parameter int                 BANK_W    = 4,
  parameter int                 ADDR_W    = 2,
  parameter logic [BANK_W-1:0]  IN_BANK   = 4'b0010,
  parameter logic [BANK_W-1:0]  OUT_BANK  = 4'b0011,
  parameter logic [ADDR_W-1:0]  LO_ADDR   = 2'b00,
  parameter logic [ADDR_W-1:0]  HI_ADDR   = 2'b01,
  parameter logic [ADDR_W-1:0]  STAT_ADDR = 2'b10
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output host_sel_e         sel
);

  logic in_hit;
  logic out_hit;

  assign in_hit  = (bank == IN_BANK);
  assign out_hit = (bank == OUT_BANK);

  always_comb begin
    sel = SEL_NONE;
    if (in_hit) begin
      if (addr == LO_ADDR)       sel = SEL_IN_LO;
      else if (addr == HI_ADDR)  sel = SEL_IN_HI;
    end else if (out_hit) begin
      if (addr == LO_ADDR)       sel = SEL_OUT_LO;
      else if (addr == HI_ADDR)  sel = SEL_OUT_HI;
      else if (addr == STAT_ADDR) sel = SEL_STATUS;
    end
  end

endmodule

// File: rtl/mbox_inbound.sv
module mbox_inbound #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic              take,
  output logic [WORD_W-1:0] word,
  output logic              ready
);

  // Two half registers, each with its own write enable
  for (genvar g = 0; g < 2; g++) begin : g_half
    logic              en;
    logic [HALF_W-1:0] half_q;

    assign en = (g == 0) ? wr_lo : wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        half_q <= '0;
      end else if (en) begin
        half_q <= wdata;
      end
    end

    assign word[g*HALF_W +: HALF_W] = half_q;
  end

  // Ready flag: the set is applied last, so it wins over a clear
  logic ready_q;
  logic ready_d;

  always_comb begin
    ready_d = ready_q;
    if (take)  ready_d = 1'b0;
    if (wr_hi) ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
    end
  end

  assign ready = ready_q;

endmodule

// File: rtl/mbox_outbound.sv
module mbox_outbound #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] ldata,
  input  logic              drain,
  output logic [WORD_W-1:0] word,
  output logic              ready
);

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= ldata;
    end
  end

  // Ready flag: the set is applied last, so it wins over a clear
  logic ready_q;
  logic ready_d;

  always_comb begin
    ready_d = ready_q;
    if (drain) ready_d = 1'b0;
    if (load)  ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
    end
  end

  assign word  = word_q;
  assign ready = ready_q;

endmodule

// File: rtl/hcpu_mailbox.sv
module hcpu_mailbox
  import mbox_pkg::*;
#(
  parameter int                HALF_W    = 16,
  parameter int                BANK_W    = 4,
  parameter int                ADDR_W    = 2,
  parameter logic [BANK_W-1:0] IN_BANK   = 4'b0010,
  parameter logic [BANK_W-1:0] OUT_BANK  = 4'b0011,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 2'b00,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 2'b01,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 2'b10,
  localparam int               WORD_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] h_bank,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [HALF_W-1:0] h_wdata,
  output logic [HALF_W-1:0] h_rdata,
  input  logic              p_wr,
  input  logic [WORD_W-1:0] p_wdata,
  input  logic              p_rd,
  output logic [WORD_W-1:0] p_rdata,
  output logic              in_ready,
  output logic              out_ready
);

  logic rst_sync_n;

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  host_sel_e sel;

  mbox_host_decode #(
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W),
    .IN_BANK   (IN_BANK),
    .OUT_BANK  (OUT_BANK),
    .LO_ADDR   (LO_ADDR),
    .HI_ADDR   (HI_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_dec (
    .bank (h_bank),
    .addr (h_addr),
    .sel  (sel)
  );

  // Host strobes qualified by the decoded location; writes elsewhere drop
  logic in_wr_lo;
  logic in_wr_hi;
  logic out_rd_hi;

  assign in_wr_lo  = h_wr && (sel == SEL_IN_LO);
  assign in_wr_hi  = h_wr && (sel == SEL_IN_HI);
  assign out_rd_hi = h_rd && (sel == SEL_OUT_HI);

  logic [WORD_W-1:0] in_word;
  logic [WORD_W-1:0] out_word;

  mbox_inbound #(.HALF_W(HALF_W)) u_in (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_lo (in_wr_lo),
    .wr_hi (in_wr_hi),
    .wdata (h_wdata),
    .take  (p_rd),
    .word  (in_word),
    .ready (in_ready)
  );

  mbox_outbound #(.HALF_W(HALF_W)) u_out (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (p_wr),
    .ldata (p_wdata),
    .drain (out_rd_hi),
    .word  (out_word),
    .ready (out_ready)
  );

  // Host read mux (next state of the host read register)
  logic [HALF_W-1:0] h_rdata_d;
  logic [HALF_W-1:0] h_rdata_q;

  always_comb begin
    unique case (sel)
      SEL_IN_LO:  h_rdata_d = in_word[HALF_W-1:0];
      SEL_IN_HI:  h_rdata_d = in_word[WORD_W-1:HALF_W];
      SEL_OUT_LO: h_rdata_d = out_word[HALF_W-1:0];
      SEL_OUT_HI: h_rdata_d = out_word[WORD_W-1:HALF_W];
      SEL_STATUS: h_rdata_d = {{(HALF_W-1){1'b0}}, out_ready};
      default:    h_rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      h_rdata_q <= '0;
    end else if (h_rd) begin
      h_rdata_q <= h_rdata_d;
    end
  end

  // Processor read register
  logic [WORD_W-1:0] p_rdata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      p_rdata_q <= '0;
    end else if (p_rd) begin
      p_rdata_q <= in_word;
    end
  end

  assign h_rdata = h_rdata_q;
  assign p_rdata = p_rdata_q;

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int                HALF_W    = 16,
  parameter int                BANK_W    = 4,
  parameter int                ADDR_W    = 2,
  parameter logic [BANK_W-1:0] IN_BANK   = 4'b0010,
  parameter logic [BANK_W-1:0] OUT_BANK  = 4'b0011,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 2'b01,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 2'b00,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 2'b10,
  localparam int               WORD_W    = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [BANK_W-1:0] h_bank,
  input logic [ADDR_W-1:0] h_addr,
  input logic              h_wr,
  input logic              h_rd,
  input logic [HALF_W-1:0] h_rdata,
  input logic              p_wr,
  input logic [WORD_W-1:0] p_wdata,
  input logic              p_rd,
  input logic [WORD_W-1:0] p_rdata,
  input logic [WORD_W-1:0] out_word,
  input logic              in_ready,
  input logic              out_ready
);

  logic wr_in_hi;
  logic rd_out_hi;
  logic rd_out_lo;
  logic rd_stat;

  assign wr_in_hi  = h_wr && (h_bank == IN_BANK)  && (h_addr == HI_ADDR);
  assign rd_out_hi = h_rd && (h_bank == OUT_BANK) && (h_addr == HI_ADDR);
  assign rd_out_lo = h_rd && (h_bank == OUT_BANK) && (h_addr == LO_ADDR);
  assign rd_stat   = h_rd && (h_bank == OUT_BANK) && (h_addr == STAT_ADDR);

  // R3
  in_set_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(in_ready) |-> $past(wr_in_hi));

  // R4
  in_take_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (p_rd && !wr_in_hi) |=> !in_ready);

  // R4
  in_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (p_rd && wr_in_hi) |=> in_ready);

  // R5
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    p_wr |=> (out_ready && out_word == $past(p_wdata)));

  // R6
  out_drain_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_out_hi && !p_wr) |=> !out_ready);

  // R6
  out_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_out_lo && out_ready) |=> out_ready);

  // R7
  status_word_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_stat |=> (h_rdata[0] == $past(out_ready) && h_rdata[HALF_W-1:1] == '0));

  // R8
  out_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !p_wr |=> $stable(out_word));

  // R10
  h_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !h_rd |=> $stable(h_rdata));

  // R10
  p_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !p_rd |=> $stable(p_rdata));

endmodule

bind hcpu_mailbox mbox_chk #(
  .HALF_W    (HALF_W),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W),
  .IN_BANK   (IN_BANK),
  .OUT_BANK  (OUT_BANK),
  .HI_ADDR   (HI_ADDR),
  .LO_ADDR   (LO_ADDR),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .h_bank     (h_bank),
  .h_addr     (h_addr),
  .h_wr       (h_wr),
  .h_rd       (h_rd),
  .h_rdata    (h_rdata),
  .p_wr       (p_wr),
  .p_wdata    (p_wdata),
  .p_rd       (p_rd),
  .p_rdata    (p_rdata),
  .out_word   (out_word),
  .in_ready   (in_ready),
  .out_ready  (out_ready)
);

// File: tb/sim_hcpu_mailbox.sv
module sim_hcpu_mailbox;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [3:0]  h_bank;
  logic [1:0]  h_addr;
  logic        h_wr;
  logic        h_rd;
  logic [15:0] h_wdata;
  logic [15:0] h_rdata;
  logic        p_wr;
  logic [31:0] p_wdata;
  logic        p_rd;
  logic [31:0] p_rdata;
  logic        in_ready;
  logic        out_ready;

  hcpu_mailbox u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_bank    (h_bank),
    .h_addr    (h_addr),
    .h_wr      (h_wr),
    .h_rd      (h_rd),
    .h_wdata   (h_wdata),
    .h_rdata   (h_rdata),
    .p_wr      (p_wr),
    .p_wdata   (p_wdata),
    .p_rd      (p_rd),
    .p_rdata   (p_rdata),
    .in_ready  (in_ready),
    .out_ready (out_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] hq[$];
  string       htag[$];
  logic [31:0] pq[$];
  string       ptag[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of strobes, launched just after a falling edge
  task automatic cyc(input logic hw, input logic hr, input logic [3:0] bank,
                     input logic [1:0] addr, input logic [15:0] hd,
                     input logic pw, input logic pr, input logic [31:0] pd);
    h_wr = hw; h_rd = hr; h_bank = bank; h_addr = addr; h_wdata = hd;
    p_wr = pw; p_rd = pr; p_wdata = pd;
    @(negedge clk);
    h_wr = 1'b0; h_rd = 1'b0; p_wr = 1'b0; p_rd = 1'b0;
  endtask

  task automatic hwrite(input logic [3:0] bank, input logic [1:0] addr, input logic [15:0] d);
    cyc(1'b1, 1'b0, bank, addr, d, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic hread(input logic [3:0] bank, input logic [1:0] addr,
                       input logic [15:0] exp, input string tag);
    hq.push_back({16'h0, exp}); htag.push_back(tag);
    cyc(1'b0, 1'b1, bank, addr, 16'h0, 1'b0, 1'b0, 32'h0);
  endtask

  // Monitor: strobes sampled at the rising edge, results compared at the next falling edge
  initial begin
    logic hs, ps;
    forever begin
      @(posedge clk);
      hs = h_rd; ps = p_rd;
      @(negedge clk);
      if (hs) begin
        if (hq.size() == 0) chk("host read with no expected item", 32'h1, 32'h0);
        else chk(htag.pop_front(), {16'h0, h_rdata}, hq.pop_front());
      end
      if (ps) begin
        if (pq.size() == 0) chk("processor read with no expected item", 32'h1, 32'h0);
        else chk(ptag.pop_front(), p_rdata, pq.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    h_bank = 4'h0; h_addr = 2'b00; h_wr = 1'b0; h_rd = 1'b0; h_wdata = 16'h0;
    p_wr = 1'b0; p_rd = 1'b0; p_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 in_ready", {31'h0, in_ready}, 32'h0);
    chk("R1 out_ready", {31'h0, out_ready}, 32'h0);
    chk("R1 h_rdata", {16'h0, h_rdata}, 32'h0);
    chk("R1 p_rdata", p_rdata, 32'h0);
    hread(4'b0010, 2'b00, 16'h0000, "R1 inbound low");
    hread(4'b0011, 2'b01, 16'h0000, "R1 outbound high");

    // R2 / R3: the low half alone does not set the flag
    hwrite(4'b0010, 2'b00, 16'h1234);
    chk("R3 low write leaves in_ready", {31'h0, in_ready}, 32'h0);
    hread(4'b0010, 2'b00, 16'h1234, "R2 inbound low readback");
    hwrite(4'b0010, 2'b01, 16'hABCD);
    chk("R3 high write sets in_ready", {31'h0, in_ready}, 32'h1);
    hread(4'b0010, 2'b01, 16'hABCD, "R2 inbound high readback");
    chk("R3 host read keeps in_ready", {31'h0, in_ready}, 32'h1);

    // R2 / R4: the processor read returns the word and clears the flag
    pq.push_back(32'hABCD1234); ptag.push_back("R2 processor word");
    cyc(1'b0, 1'b0, 4'h0, 2'b00, 16'h0, 1'b0, 1'b1, 32'h0);
    chk("R4 take clears in_ready", {31'h0, in_ready}, 32'h0);

    // R4 / R11: a collision with a high-half write; the set wins and the read returns old data
    pq.push_back(32'hABCD1234); ptag.push_back("R11 processor read returns old word");
    cyc(1'b1, 1'b0, 4'b0010, 2'b01, 16'h5555, 1'b0, 1'b1, 32'h0);
    chk("R4 set wins over take", {31'h0, in_ready}, 32'h1);

    // R5 / R7
    cyc(1'b0, 1'b0, 4'h0, 2'b00, 16'h0, 1'b1, 1'b0, 32'hDEADBEEF);
    chk("R5 load sets out_ready", {31'h0, out_ready}, 32'h1);
    hread(4'b0011, 2'b10, 16'h0001, "R7 status with flag set");
    chk("R7 status read keeps out_ready", {31'h0, out_ready}, 32'h1);

    // R8: writes to the outbound bank are ignored; R6: a low-half read keeps the flag
    hwrite(4'b0011, 2'b00, 16'hFFFF);
    hwrite(4'b0011, 2'b01, 16'hFFFF);
    hread(4'b0011, 2'b00, 16'hBEEF, "R8 outbound low unchanged");
    chk("R6 low read keeps out_ready", {31'h0, out_ready}, 32'h1);
    hread(4'b0011, 2'b01, 16'hDEAD, "R8 outbound high unchanged");
    chk("R6 high read clears out_ready", {31'h0, out_ready}, 32'h0);
    hread(4'b0011, 2'b10, 16'h0000, "R7 status with flag clear");

    // R6 / R11: a high-half read together with a processor write
    hq.push_back(32'h0000DEAD); htag.push_back("R11 host read returns old half");
    cyc(1'b0, 1'b1, 4'b0011, 2'b01, 16'h0, 1'b1, 1'b0, 32'h00C0FFEE);
    chk("R6 set wins over drain", {31'h0, out_ready}, 32'h1);
    hread(4'b0011, 2'b00, 16'hFFEE, "R5 new outbound low");
    hread(4'b0011, 2'b01, 16'h00C0, "R5 new outbound high");
    chk("R6 flag drained", {31'h0, out_ready}, 32'h0);

    // R9: unmapped locations
    hwrite(4'b0001, 2'b00, 16'h7777);
    hwrite(4'b0010, 2'b10, 16'h7777);
    hread(4'b0011, 2'b11, 16'h0000, "R9 outbound bank address 3");
    hread(4'b0010, 2'b10, 16'h0000, "R9 inbound bank address 2");
    hread(4'b0010, 2'b11, 16'h0000, "R9 inbound bank address 3");
    hread(4'b0001, 2'b00, 16'h0000, "R9 foreign bank");
    hread(4'b0010, 2'b00, 16'h1234, "R9 inbound low undisturbed");

    // R10: read data holds across idle cycles
    hread(4'b0010, 2'b01, 16'h5555, "R10 inbound high");
    repeat (3) @(negedge clk);
    chk("R10 h_rdata holds", {16'h0, h_rdata}, 32'h00005555);
    chk("R10 p_rdata holds", p_rdata, 32'hABCD1234);

    @(negedge clk);
    chk("scoreboard drained", hq.size() + pq.size(), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule